// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects up to eight event inputs from pins or peripherals and holds one pending flag for each. It passes them to a simple CPU as a single request line and a binary vector index. Each input is first brought into the clock domain by a two-flop synchronizer. It is then detected in one of two ways. In edge mode it is detected on a rising, falling or either edge. In level mode it is detected while it sits at an active high or active low level.

Pending flags are masked by a per-source enable and by a global enable. A fixed-priority arbiter picks the lowest pending index and presents it on the vector output. When the CPU acknowledges, a source configured for auto-clear has its flag dropped by hardware. Any other source keeps its flag until software writes a 1 to that flag's bit.

A small register port gives access to the enables, the flags, the trigger configuration and the auto-clear selection. Flags are cleared only by writing ones, so clearing one flag cannot drop an event that another source raised at the same time.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, the enable, flag, dual-edge, auto-clear and global-enable registers read 0, the mode and polarity registers read all ones, and irq_req is 0.
- R2: irq_req is 1 exactly when some source has both its flag and its enable bit set and the global enable (bit 0 of address 6) is 1. Clearing the global enable masks the request but leaves every flag unchanged.
- R3: Among the enabled pending sources, the lowest index wins. irq_vec carries that index in binary.
- R4: Writing to address 1 clears every flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R5: An irq_ack while irq_req is 1 clears the presented flag only if that source's auto-clear bit (address 5) is 1. Otherwise the flag remains set.
- R6: In edge mode (mode bit 1 at address 2), a source sets its flag once per qualifying edge, however long the input then stays steady. The edge is rising when its polarity bit (address 3) is 1 and falling when it is 0. When its dual-edge bit (address 4) is 1, both edges qualify.
- R7: In level mode (mode bit 0), a source sets its flag in every cycle its input is at the active level: high when its polarity bit is 1, low when it is 0. The flag therefore reappears after a clear while that level persists.
- R8: When a detected event and a clear (by write or by acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: A change on src_in is visible in the flag register three rising clock edges after it is driven, and not after two.
- R10: The register addresses are: enable 0, flags 1, mode 2, polarity 3, dual-edge 4, auto-clear 5, global enable 6. reg_rdata shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NUM_SRC | Raw event inputs, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Read data for reg_addr |
| irq_req | output | 1 | Request to the CPU |
| irq_vec | output | VEC_W | Index of the presented source |
| irq_ack | input | 1 | CPU acknowledge of the presented source |

## Verification
The bench builds the block with its defaults: eight sources and a three-bit vector. At that size every index from 0 to 7 can win arbitration, and the highest index can be reached only once all lower ones are cleared or masked. Eight sources also fill the flag register exactly, so a clear pattern covers every bit position. One source is switched between edge, dual-edge and level trigger, and between both polarities. This makes the same-cycle clear-versus-event collision and the synchronizer latency observable at the flag register.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int MAX_SRC = 8;

  typedef enum logic [2:0] {
    RA_ENABLE = 3'd0,
    RA_FLAGS  = 3'd1,
    RA_MODE   = 3'd2,
    RA_POL    = 3'd3,
    RA_DUAL   = 3'd4,
    RA_AUTO   = 3'd5,
    RA_GLOBAL = 3'd6
  } reg_addr_e;

  // Event for one source given its configuration and synchronized samples.
  function automatic logic detect_event(input logic edge_mode, input logic pol,
                                        input logic dual, input logic cur,
                                        input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (edge_mode)
      return dual ? (rise | fall) : (pol ? rise : fall);
    else
      return pol ? cur : ~cur;
  endfunction

  // Lowest set bit index of an 8-bit vector; 0 when empty.
  function automatic logic [2:0] lowest_index(input logic [MAX_SRC-1:0] v);
    logic [2:0] r;
    r = 3'd0;
    for (int i = MAX_SRC - 1; i >= 0; i--)
      if (v[i]) r = 3'(i);
    return r;
  endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else if (g == 0) stage[g] <= d;
        else stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/irqc_detect.sv
module irqc_detect
  import irqc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sync_in,
  input  logic [N-1:0] mode_edge,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] dual,
  output logic [N-1:0] ev
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_in;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_det
      assign ev[g] = detect_event(mode_edge[g], pol[g], dual[g], sync_in[g], prev_q[g]);
    end
  endgenerate
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flags_q;

  // An event in the clear cycle wins, so it is never lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr) | ev;
  end

  assign flags = flags_q;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int N     = 8,
  parameter int VEC_W = 3
) (
  input  logic [N-1:0]     pend,
  input  logic [N-1:0]     enable,
  input  logic             global_en,
  output logic             req,
  output logic [VEC_W-1:0] vec
);
  logic [N-1:0]       masked;
  logic [MAX_SRC-1:0] padded;
  logic [2:0]         win;

  always_comb begin
    masked         = pend & enable;
    padded         = '0;
    padded[N-1:0]  = masked;
    win            = lowest_index(padded);
    req            = global_en & (|masked);
    vec            = win[VEC_W-1:0];
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  input  logic               irq_ack,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec
);
  localparam logic [NUM_SRC-1:0] ONE_HOT0 = NUM_SRC'(1);

  logic [NUM_SRC-1:0] en_q, mode_q, pol_q, dual_q, auto_q;
  logic               gie_q;
  logic [NUM_SRC-1:0] sync_s, ev_vec, flags, clr_vec, w1c_vec, ack_clr;
  logic               ack_take;

  // Configuration registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '1;
      pol_q  <= '1;
      dual_q <= '0;
      auto_q <= '0;
      gie_q  <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_ENABLE: en_q   <= reg_wdata;
        RA_MODE:   mode_q <= reg_wdata;
        RA_POL:    pol_q  <= reg_wdata;
        RA_DUAL:   dual_q <= reg_wdata;
        RA_AUTO:   auto_q <= reg_wdata;
        RA_GLOBAL: gie_q  <= reg_wdata[0];
        default:   ;
      endcase
    end
  end

  irqc_sync #(.WIDTH(NUM_SRC), .STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(sync_s));

  irqc_detect #(.N(NUM_SRC)) det_i (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_s), .mode_edge(mode_q),
    .pol(pol_q), .dual(dual_q), .ev(ev_vec));

  always_comb begin
    w1c_vec  = (reg_wr && reg_addr == RA_FLAGS) ? reg_wdata : '0;
    ack_take = irq_ack & irq_req & auto_q[irq_vec];
    ack_clr  = ack_take ? (ONE_HOT0 << irq_vec) : '0;
    clr_vec  = w1c_vec | ack_clr;
  end

  irqc_flags #(.N(NUM_SRC)) flg_i (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr(clr_vec), .flags(flags));

  irqc_arbiter #(.N(NUM_SRC), .VEC_W(VEC_W)) arb_i (
    .pend(flags), .enable(en_q), .global_en(gie_q), .req(irq_req), .vec(irq_vec));

  always_comb begin
    case (reg_addr)
      RA_ENABLE: reg_rdata = en_q;
      RA_FLAGS:  reg_rdata = flags;
      RA_MODE:   reg_rdata = mode_q;
      RA_POL:    reg_rdata = pol_q;
      RA_DUAL:   reg_rdata = dual_q;
      RA_AUTO:   reg_rdata = auto_q;
      RA_GLOBAL: reg_rdata = {{(NUM_SRC-1){1'b0}}, gie_q};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NUM_SRC = 8,
  parameter int VEC_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_req,
  input logic [VEC_W-1:0]   irq_vec,
  input logic               irq_ack,
  input logic               gie_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] auto_q,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] ev_vec,
  input logic [NUM_SRC-1:0] clr_vec
);
  localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

  // R2: no request while the global enable is off
  a_r2_global_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq_req);

  // R3: presented source is pending, enabled, and no lower index is
  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flags[irq_vec] && en_q[irq_vec] &&
                 ((flags & en_q & ((ONE << irq_vec) - ONE)) == '0)));

  // R4: a flag not being cleared stays set
  a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ($past(flags) & ~$past(clr_vec))) == ($past(flags) & ~$past(clr_vec))));

  // R5: auto-clear on acknowledge when no new event
  a_r5_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && auto_q[irq_vec] && !ev_vec[irq_vec]) |=> !flags[$past(irq_vec)]);

  // R8: a detected event always leaves its flag set
  a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(ev_vec)) == $past(ev_vec)));

  // R6: a flag never rises without an event
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(ev_vec)) == '0));
endmodule

bind irq_vector_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack),
  .gie_q(gie_q), .en_q(en_q), .auto_q(auto_q), .flags(flags), .ev_vec(ev_vec),
  .clr_vec(clr_vec));

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_in = '0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         irq_ack = 1'b0;
  logic         irq_req;
  logic [2:0]   irq_vec;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl #(.NUM_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec));

  // {pattern, enable, expected req, expected vector}
  localparam logic [19:0] VEC_TAB [6] = '{
    {8'h01, 8'hFF, 1'b1, 3'd0},
    {8'h84, 8'hFF, 1'b1, 3'd2},
    {8'h84, 8'h80, 1'b1, 3'd7},
    {8'h84, 8'h03, 1'b0, 3'd0},
    {8'hF0, 8'hE0, 1'b1, 3'd5},
    {8'h0A, 8'h0A, 1'b1, 3'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_src(input logic [N-1:0] p);
    @(negedge clk); src_in = p;
    cyc(4);
    src_in = '0;
    cyc(4);
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    cyc(3);
    #1;
    check("R1 req after reset", irq_req, 0);
    rst_n = 1'b1;
    rd(3'd0, d); check("R1 R10 enable reset", d, 8'h00);
    rd(3'd1, d); check("R1 R10 flags reset", d, 8'h00);
    rd(3'd2, d); check("R1 R10 mode reset", d, 8'hFF);
    rd(3'd3, d); check("R1 R10 polarity reset", d, 8'hFF);
    rd(3'd4, d); check("R1 R10 dual reset", d, 8'h00);
    rd(3'd5, d); check("R1 R10 auto reset", d, 8'h00);
    rd(3'd6, d); check("R1 R10 global reset", d, 8'h00);

    // Table of arbitration cases (R2, R3, R6)
    wr(3'd6, 8'h01);
    for (int i = 0; i < 6; i++) begin
      wr(3'd1, 8'hFF);
      wr(3'd0, VEC_TAB[i][11:4]);
      pulse_src(VEC_TAB[i][19:12]);
      rd(3'd1, d);
      check("R6 table flags", d, VEC_TAB[i][19:12]);
      check("R2 table req", irq_req, VEC_TAB[i][3]);
      if (VEC_TAB[i][3]) check("R3 table vec", irq_vec, VEC_TAB[i][2:0]);
    end

    // R2: global enable masks but keeps flags
    wr(3'd1, 8'hFF); wr(3'd0, 8'hFF);
    pulse_src(8'h84);
    wr(3'd6, 8'h00);
    rd(3'd1, d);
    check("R2 masked req", irq_req, 0);
    check("R2 flags kept", d, 8'h84);
    wr(3'd6, 8'h01);
    #1;
    check("R2 unmasked req", irq_req, 1);
    check("R3 vec after unmask", irq_vec, 2);

    // R4: write-1-to-clear
    wr(3'd1, 8'h04);
    rd(3'd1, d); check("R4 clear one bit", d, 8'h80);
    wr(3'd1, 8'h00);
    rd(3'd1, d); check("R4 zero write keeps", d, 8'h80);
    check("R3 vec now 7", irq_vec, 7);

    // R5: auto-clear versus software-clear
    wr(3'd1, 8'hFF);
    wr(3'd5, 8'h80);
    pulse_src(8'h84);
    ack();
    rd(3'd1, d); check("R5 ack without auto keeps", d, 8'h84);
    wr(3'd1, 8'h04);
    #1; check("R5 vec 7 presented", irq_vec, 7);
    ack();
    rd(3'd1, d); check("R5 ack with auto clears", d, 8'h00);
    check("R5 req drops", irq_req, 0);
    wr(3'd5, 8'h00);

    // R6: one set per edge while held
    @(negedge clk); src_in = 8'h08;
    cyc(4);
    rd(3'd1, d); check("R6 rising sets", d, 8'h08);
    wr(3'd1, 8'h08);
    cyc(10);
    rd(3'd1, d); check("R6 held input no repeat", d, 8'h00);
    wr(3'd3, 8'hF7);
    @(negedge clk); src_in = 8'h00;
    cyc(4);
    rd(3'd1, d); check("R6 falling sets", d, 8'h08);
    wr(3'd1, 8'h08);
    wr(3'd4, 8'h08);
    @(negedge clk); src_in = 8'h08;
    cyc(4);
    rd(3'd1, d); check("R6 dual rising", d, 8'h08);
    wr(3'd1, 8'h08);
    @(negedge clk); src_in = 8'h00;
    cyc(4);
    rd(3'd1, d); check("R6 dual falling", d, 8'h08);
    wr(3'd4, 8'h00); wr(3'd3, 8'hFF); wr(3'd1, 8'hFF);

    // R7, R8: level mode
    wr(3'd2, 8'hFD);
    @(negedge clk); src_in = 8'h02;
    cyc(4);
    rd(3'd1, d); check("R7 level sets", d, 8'h02);
    wr(3'd1, 8'h02);
    rd(3'd1, d); check("R8 R7 clear during active level keeps", d, 8'h02);
    @(negedge clk); src_in = 8'h00;
    cyc(4);
    wr(3'd1, 8'h02);
    rd(3'd1, d); check("R7 inactive level clears", d, 8'h00);
    wr(3'd3, 8'hFD);
    cyc(4);
    rd(3'd1, d); check("R7 active-low level sets", d, 8'h02);
    @(negedge clk); src_in = 8'h02;
    cyc(4);
    wr(3'd1, 8'h02);
    rd(3'd1, d); check("R7 active-low released", d, 8'h00);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    @(negedge clk); src_in = 8'h00;
    cyc(4);
    wr(3'd1, 8'hFF);

    // R9: synchronizer latency
    @(negedge clk); reg_addr = 3'd1; src_in = 8'h01;
    cyc(2); #1;
    check("R9 not after two edges", reg_rdata[0], 0);
    cyc(1); #1;
    check("R9 set after three edges", reg_rdata[0], 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule